// File: doc/BRIEF.md
# Page Table Entry Run Writer

This block fills a contiguous stretch of 64-bit page table entries for one physically contiguous mapping. A caller hands it one request: a starting entry index, an entry count, a base physical address, the address step from one page to the next, and the attribute fields of the mapping. The block then writes one entry per cycle to a simple memory write port. The address of each write is the byte offset of the entry.

The range is split into naturally aligned power-of-two runs of at most 128 entries. Every entry of a run carries the run's log2 size, so translation hardware can cache the run as a single large page. An unmap request uses the same walk over the range but writes zero entries instead.

A request is taken only while the block is idle. A one-cycle done pulse marks the end of each request.

Top module: `pte_run_writer`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. A request offered while the block is busy has no effect on the entries written. While idle, `wr_valid` is low.
- R2: Each run's length is the largest power of two, at most 128, that does not exceed the number of entries still to write and to which the current entry index is aligned.
- R3: In map mode, every entry of a run holds the same value: the run's physical address ORed with the attribute fields and with the run's log2 length in bits 9:7.
- R4: The first run uses the base address. Each later run's address is the previous run's address plus the run length times the per-page stride.
- R5: `wr_addr` is the entry index times 8. Consecutive writes of one request step by 8.
- R6: An unmap request writes all-zero entries over the whole requested range.
- R7: In map mode, the attribute fields sit at fixed positions:
  - bit 0 is 1 (valid);
  - bit 3 is read-only;
  - bits 5:4 are the aperture (0 local video memory, 2 coherent host, 3 non-coherent host), passed through unchanged;
  - bit 6 is privileged;
  - bits 46:40 are the 7-bit kind;
  - bits 48:47 are the compression mode.
- R8: While `wr_valid` is high and `wr_ready` is low, the pending write holds its address and data and stays valid.
- R9: `done` is high for exactly one cycle, in the cycle after the last write is accepted. At that point the block is idle again.
- R10: A request with a count of zero makes no writes and raises `done` in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_unmap | input | 1 | 1 = write zero entries |
| req_index | input | IDX_W | First entry index |
| req_count | input | CNT_W | Number of entries |
| req_base | input | PA_W | Physical address of the first page |
| req_stride | input | PA_W | Address step per page |
| req_ro | input | 1 | Read-only attribute |
| req_aper | input | 2 | Aperture code |
| req_priv | input | 1 | Privileged attribute |
| req_kind | input | 7 | Memory kind |
| req_comp | input | 2 | Compression mode |
| wr_valid | output | 1 | Entry write pending |
| wr_ready | input | 1 | Write port accepts |
| wr_addr | output | IDX_W+3 | Byte offset of the entry |
| wr_data | output | 64 | Entry value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches the per-cycle rules on every cycle:
- no write while idle;
- a stalled write keeps its address and data;
- byte addresses step by 8 within a request;
- unmap entries are zero and map entries carry the valid bit;
- `done` only appears together with idle.

The run split, the run-size field and the per-run address advance depend on the whole index and count history. Only the bench's directed scenarios show those against an independently computed entry list. The same holds for the attribute packing, the zero-count completion, and the fact that a request offered while busy is ignored.

// File: rtl/pte_run_writer.sv
module pte_run_writer #(
  parameter int IDX_W = 24,
  parameter int CNT_W = 24,
  parameter int PA_W  = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_unmap,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [CNT_W-1:0]   req_count,
  input  logic [PA_W-1:0]    req_base,
  input  logic [PA_W-1:0]    req_stride,
  input  logic               req_ro,
  input  logic [1:0]         req_aper,
  input  logic               req_priv,
  input  logic [6:0]         req_kind,
  input  logic [1:0]         req_comp,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [IDX_W+2:0]   wr_addr,
  output logic [63:0]        wr_data,
  output logic               done
);

  localparam int MAX_LG = 7;
  localparam int LG_W   = 3;
  localparam int RUN_W  = MAX_LG + 1;

  logic              busy;
  logic              unmap_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  rem_q;
  logic [PA_W-1:0]   addr_q;
  logic [PA_W-1:0]   stride_q;
  logic [63:0]       attr_q;
  logic [RUN_W-1:0]  run_left_q;
  logic [LG_W-1:0]   run_lg_q;
  logic              done_q;

  logic [MAX_LG:0]   fit;
  logic [LG_W-1:0]   calc_lg;
  logic              new_run;
  logic [LG_W-1:0]   eff_lg;
  logic [RUN_W-1:0]  eff_left;
  logic              fire;
  logic [63:0]       attr_d;

  for (genvar k = 0; k <= MAX_LG; k++) begin : g_fit
    if (k == 0) begin : g_one
      assign fit[k] = rem_q != '0;
    end else begin : g_pow
      assign fit[k] = (rem_q >= (CNT_W'(1) << k)) && (idx_q[k-1:0] == '0);
    end
  end

  always_comb begin
    calc_lg = '0;
    for (int k = 1; k <= MAX_LG; k++)
      if (fit[k]) calc_lg = LG_W'(k);
  end

  assign new_run   = run_left_q == '0;
  assign eff_lg    = new_run ? calc_lg : run_lg_q;
  assign eff_left  = new_run ? (RUN_W'(1) << calc_lg) : run_left_q;

  assign req_ready = !busy;
  assign wr_valid  = busy;
  assign fire      = wr_valid && wr_ready;
  assign wr_addr   = {idx_q, 3'b000};
  assign wr_data   = unmap_q ? 64'd0
                   : (attr_q | 64'(addr_q) | (64'(eff_lg) << 7));
  assign done      = done_q;

  assign attr_d = (64'(req_comp) << 47) | (64'(req_kind) << 40)
                | (64'(req_priv) << 6)  | (64'(req_aper) << 4)
                | (64'(req_ro) << 3)    | 64'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      unmap_q    <= 1'b0;
      idx_q      <= '0;
      rem_q      <= '0;
      addr_q     <= '0;
      stride_q   <= '0;
      attr_q     <= '0;
      run_left_q <= '0;
      run_lg_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          idx_q      <= req_index;
          rem_q      <= req_count;
          addr_q     <= req_base;
          stride_q   <= req_stride;
          attr_q     <= attr_d;
          unmap_q    <= req_unmap;
          run_left_q <= '0;
          run_lg_q   <= '0;
          if (req_count == '0) done_q <= 1'b1;
          else                 busy   <= 1'b1;
        end
      end else if (fire) begin
        idx_q      <= idx_q + 1'b1;
        rem_q      <= rem_q - 1'b1;
        run_lg_q   <= eff_lg;
        run_left_q <= eff_left - 1'b1;
        if (eff_left == RUN_W'(1))
          addr_q <= addr_q + (stride_q << eff_lg);
        if (rem_q == CNT_W'(1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pte_run_writer_chk.sv
module pte_run_writer_chk #(
  parameter int IDX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [IDX_W+2:0] wr_addr,
  input logic [63:0]      wr_data,
  input logic             done,
  input logic             unmap_q
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wr_valid); // R1

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid || (wr_addr == $past(wr_addr) + 8)); // R5

  AST_UNMAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && unmap_q |-> wr_data == 64'd0); // R6

  AST_MAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !unmap_q |-> wr_data[0]); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !wr_valid); // R9

endmodule

bind pte_run_writer pte_run_writer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
  .unmap_q(unmap_q)
);

// File: tb/pte_run_writer_tb.sv
module pte_run_writer_tb;
  localparam int IDX_W = 24;
  localparam int CNT_W = 24;
  localparam int PA_W  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_unmap = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic [PA_W-1:0]  req_base = '0, req_stride = '0;
  logic req_ro = 1'b0, req_priv = 1'b0;
  logic [1:0] req_aper = '0, req_comp = '0;
  logic [6:0] req_kind = '0;
  logic req_ready, wr_valid, done;
  logic wr_ready = 1'b1;
  logic [IDX_W+2:0] wr_addr;
  logic [63:0] wr_data;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pte_run_writer #(.IDX_W(IDX_W), .CNT_W(CNT_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_unmap(req_unmap), .req_index(req_index), .req_count(req_count),
    .req_base(req_base), .req_stride(req_stride), .req_ro(req_ro),
    .req_aper(req_aper), .req_priv(req_priv), .req_kind(req_kind),
    .req_comp(req_comp), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_req(input longint idx, input longint cnt, input longint base,
                         input longint stride, input bit unmap, input bit ro,
                         input logic [1:0] aper, input bit priv, input logic [6:0] kind,
                         input logic [1:0] comp, input int stall_every, input bit poke,
                         input string tag);
    longint cur = idx;
    longint rem = cnt;
    longint eaddr = base;
    longint n = 0;
    logic [63:0] attr;
    logic [63:0] expv;
    attr = (64'(comp) << 47) | (64'(kind) << 40) | (64'(priv) << 6) |
           (64'(aper) << 4) | (64'(ro) << 3) | 64'd1;
    @(negedge clk);
    req_valid = 1'b1; req_unmap = unmap; req_index = IDX_W'(idx);
    req_count = CNT_W'(cnt); req_base = PA_W'(base); req_stride = PA_W'(stride);
    req_ro = ro; req_aper = aper; req_priv = priv; req_kind = kind; req_comp = comp;
    @(negedge clk);
    req_valid = 1'b0;
    if (cnt == 0) begin
      chk(done == 1'b1, "R10 done after zero count", 64'(done), 64'd1);
      chk(wr_valid == 1'b0, "R10 no write on zero count", 64'(wr_valid), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", 64'(done), 64'd0);
      chk(wr_valid == 1'b0, "R10 still no write", 64'(wr_valid), 64'd0);
      return;
    end
    if (poke) begin
      req_valid = 1'b1; req_index = IDX_W'(24'h5a5a5); req_count = CNT_W'(3);
      req_base = PA_W'(40'hff_ffff_0000); req_unmap = ~unmap;
    end
    while (rem > 0) begin
      int lg = 7;
      while (lg > 0 && !(((64'd1 << lg) <= rem) && ((cur % (64'd1 << lg)) == 0))) lg--;
      for (int j = 0; j < (1 << lg); j++) begin
        expv = unmap ? 64'd0 : (attr | 64'(eaddr) | (64'(lg) << 7));
        if (n == 0)
          chk(req_ready == 1'b0, "R1 busy drops req_ready", 64'(req_ready), 64'd0);
        if (stall_every != 0 && (n % stall_every) == 0) begin
          wr_ready = 1'b0;
          @(negedge clk);
          chk(wr_valid == 1'b1, "R8 valid held in stall", 64'(wr_valid), 64'd1);
          chk(wr_data == expv, "R8 data held in stall", wr_data, expv);
          wr_ready = 1'b1;
        end
        if (poke && rem == 1 && j == (1 << lg) - 1) req_valid = 1'b0;
        chk(wr_valid == 1'b1, {tag, " R1 write pending"}, 64'(wr_valid), 64'd1);
        chk(64'(wr_addr) == 64'(cur * 8), "R5 byte offset", 64'(wr_addr), 64'(cur * 8));
        chk(wr_data == expv, tag, wr_data, expv);
        @(negedge clk);
        cur++; n++;
      end
      eaddr += stride << lg;
      rem -= (1 << lg);
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R9 done after last write", 64'(done), 64'd1);
    chk(wr_valid == 1'b0 && req_ready == 1'b1, "R9 idle after last write",
        64'({wr_valid, req_ready}), 64'b01);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(wr_valid == 1'b0, "R1 reset no write", 64'(wr_valid), 64'd0);
    chk(done == 1'b0, "R9 reset no done", 64'(done), 64'd0);
  endtask

  task automatic t_aligned_big;
    run_req(0, 256, 64'h12_3400_0000, 64'h1000, 0, 0, 2'd0, 0, 7'h00, 2'd0, 0, 0, "R2 R3 R4 aligned");
  endtask

  task automatic t_unaligned;
    run_req(5, 150, 64'h00_8000_0000, 64'h10000, 0, 1, 2'd2, 0, 7'h11, 2'd0, 0, 0, "R2 R3 R4 unaligned");
  endtask

  task automatic t_short;
    run_req(3, 7, 64'h00_0010_0000, 64'h1000, 0, 0, 2'd3, 0, 7'h00, 2'd0, 0, 0, "R2 R4 short");
  endtask

  task automatic t_unmap;
    run_req(9, 12, 64'h00_4000_0000, 64'h1000, 1, 1, 2'd2, 1, 7'h7f, 2'd3, 0, 0, "R6 unmap zero");
  endtask

  task automatic t_stall;
    run_req(6, 10, 64'h00_0200_0000, 64'h1000, 0, 0, 2'd0, 1, 7'h05, 2'd1, 3, 0, "R8 R3 stalled");
  endtask

  task automatic t_zero;
    run_req(40, 0, 64'h00_0300_0000, 64'h1000, 0, 0, 2'd0, 0, 7'h00, 2'd0, 0, 0, "R10");
  endtask

  task automatic t_attrs;
    run_req(17, 1, 64'h00_0500_0000, 64'h1000, 0, 0, 2'd3, 1, 7'h7f, 2'd3, 0, 0, "R7 attrs a");
    run_req(64, 2, 64'h00_0600_0000, 64'h1000, 0, 1, 2'd2, 0, 7'h2a, 2'd2, 0, 0, "R7 attrs b");
  endtask

  task automatic t_busy_ignore;
    run_req(130, 9, 64'h00_0700_0000, 64'h1000, 0, 0, 2'd0, 0, 7'h03, 2'd0, 0, 1, "R1 busy request ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned_big();
    t_unaligned();
    t_short();
    t_unmap();
    t_stall();
    t_zero();
    t_attrs();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule